// File: doc/BRIEF.md
# Multi-Format Audio Serial Input Port

This block receives audio samples for six output channels from serial pins that share one bit clock and one frame clock. The port is a slave: both clocks come from an external controller. They are brought into the system clock domain through two-flop synchronizers, and their edges are found there. The data pins pass through the same synchronizer stages, so each data bit stays aligned with the bit-clock edge that samples it.

Five framing formats are supported:
- a left-aligned stereo format;
- a right-aligned stereo format;
- a stereo format whose first bit lags the frame edge by one bit;
- a pulse-framed stereo format;
- a packed time-division format that carries all six channels on data pin 0.

Words of 16, 20 or 24 bits are left-aligned into 24-bit two's complement samples, with zeros in the unused low bits. An optional replicate mode copies the first stereo pair onto the other two pairs.

Each completed frame is offered on a valid/ready output.
- While `out_valid` is high and `out_ready` is low, `out_data` holds its value.
- A frame that completes during such a stall is discarded. The held sample set is never overwritten.
- When `out_ready` is high in the cycle a new frame completes, the new set replaces the old one and `out_valid` stays high.
- `fmt` and `wlen` are to be changed only while the block is held in reset.

Top module: `aud_sin_port`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is all zeros.
- R2: With `fmt`=000 (left-aligned), the frame clock high marks the left half. The word's MSB is the bit sampled on the first rising bit-clock edge after the frame clock changes level. In stereo formats, pin k carries pair k, and output channel index 2k (left) and 2k+1 (right) sit at `out_data[24*idx +: 24]`.
- R3: With `fmt`=001, the frame clock low marks the left half, and the MSB is sampled one bit clock after the frame-clock change.
- R4: With `fmt`=010 (right-aligned), the frame clock high marks the left half, and the word's LSB is the 32nd bit of each half. Each half is 32 bit clocks long.
- R5: With `fmt`=011, a frame clock that is high for one bit clock starts a frame. The left word's MSB is sampled on that same edge, and the right word follows straight after the left word's LSB.
- R6: With `fmt`=100 (packed), bits are sampled on falling bit-clock edges from pin 0 only. A frame pulse starts eight 32-bit slots, and slot n (0 to 5) fills output channel n. Pins 1 and 2 have no effect.
- R7: `wlen`=00 selects 16-bit words, 01 selects 20-bit words, and 10 or 11 selects 24-bit words. A shorter word lands in the upper bits of its 24-bit output field, and the lower bits are 0.
- R8: With `rep_en`=1 when a frame is taken, output channels 2 and 4 equal channel 0, and channels 3 and 5 equal channel 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` stays unchanged, and a frame completing during the stall is discarded.
- R10: After a handshake with no new frame completing, `out_valid` drops to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | External bit clock (asynchronous) |
| fclk_in | input | 1 | External frame clock (asynchronous) |
| sd_in | input | 3 | Serial data, one pin per stereo pair |
| fmt | input | 3 | Framing format select |
| wlen | input | 2 | Word length select |
| rep_en | input | 1 | Copy first pair onto all pairs |
| out_ready | input | 1 | Consumer accepts the sample set |
| out_valid | output | 1 | A sample set is offered |
| out_data | output | 144 | Six 24-bit samples, channel 0 in the low bits |

## Verification
The bench uses the default parameters:
- 24-bit samples;
- three pairs;
- 32-bit stereo halves;
- eight 32-bit packed slots.

These values put a full 256-bit packed frame within reach, with unused slots 6 and 7 and noise on the idle pins. They also exercise the widest right-aligned lead-in (16 unused bits at word length 16) and the 8-bit and 4-bit zero padding.

The bit clock runs at eight system clocks per period, which leaves the synchronizer latency well inside each half bit. Directed frames with distinct patterns per channel check each format's alignment. A second frame sent during a stall shows that the held output survives.

// File: rtl/aud_sin_pkg.sv
package aud_sin_pkg;

  typedef enum logic [2:0] {
    FMT_LJ  = 3'd0,
    FMT_I2S = 3'd1,
    FMT_RJ  = 3'd2,
    FMT_DSP = 3'd3,
    FMT_TDM = 3'd4
  } fmt_e;

  // Decoded word length in bits for the wlen field.
  function automatic logic [5:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    word_bits = 6'd16;
      2'd1:    word_bits = 6'd20;
      default: word_bits = 6'd24;
    endcase
  endfunction

endpackage

// File: rtl/aud_sin_sync.sv
module aud_sin_sync #(
  parameter int N        = 5,
  parameter int EDGE_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out,
  output logic         edge_rise,
  output logic         edge_fall
);

  logic [N-1:0] stage1;
  logic [N-1:0] stage2;
  logic         edge_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1    <= '0;
      stage2    <= '0;
      edge_prev <= 1'b0;
    end else begin
      stage1    <= async_in;
      stage2    <= stage1;
      edge_prev <= stage2[EDGE_BIT];
    end
  end

  assign sync_out  = stage2;
  assign edge_rise = stage2[EDGE_BIT] & ~edge_prev;
  assign edge_fall = ~stage2[EDGE_BIT] & edge_prev;

endmodule

// File: rtl/aud_sin_frame.sv
module aud_sin_frame
  import aud_sin_pkg::*;
#(
  parameter int HALF  = 32,
  parameter int SLOT  = 32,
  parameter int NSLOT = 8,
  parameter int NUSED = 6,
  localparam int SPAN = NSLOT * SLOT,
  localparam int CW   = $clog2(SPAN) + 1,
  localparam int KW   = $clog2(SLOT),
  localparam int SLW  = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample,
  input  logic           fclk,
  input  fmt_e           fmt,
  input  logic [5:0]     wbits,
  output logic           wr_en,
  output logic [SLW-1:0] wr_slot,
  output logic [KW-1:0]  wr_pos,
  output logic           frame_done
);

  localparam logic [CW-1:0] HALF_C = CW'(HALF);
  localparam logic [CW-1:0] SPAN_C = CW'(SPAN);
  localparam logic [CW-1:0] LAST_C = '1;

  logic          prev_f;
  logic [CW-1:0] cnt;
  logic          ch_r;
  logic          armed;

  logic          frame_mode;
  logic          start;
  logic [CW-1:0] pos;
  logic [CW-1:0] w_c;
  logic          left_lvl;
  logic          ch;
  logic          arm_now;
  logic          en;
  logic [CW-1:0] kk;
  logic [SLW-1:0] slot;
  logic          last_word;

  always_comb begin
    w_c        = CW'(wbits);
    frame_mode = (fmt == FMT_DSP) || (fmt == FMT_TDM);
    start      = frame_mode ? (fclk & ~prev_f) : (fclk ^ prev_f);
    pos        = start ? '0 : cnt;
    left_lvl   = (fmt == FMT_I2S) ? ~fclk : fclk;
    ch         = start ? ~left_lvl : ch_r;
    arm_now    = start && (frame_mode || left_lvl);
    en         = 1'b0;
    kk         = '0;
    slot       = '0;
    last_word  = 1'b0;
    case (fmt)
      FMT_I2S: begin
        en        = (pos != '0) && (pos <= w_c);
        kk        = pos - CW'(1);
        slot      = SLW'(ch);
        last_word = ch;
      end
      FMT_RJ: begin
        en        = (pos >= (HALF_C - w_c)) && (pos < HALF_C);
        kk        = pos - (HALF_C - w_c);
        slot      = SLW'(ch);
        last_word = ch;
      end
      FMT_DSP: begin
        if (pos < w_c) begin
          en = 1'b1;
          kk = pos;
        end else if (pos < (w_c << 1)) begin
          en        = 1'b1;
          kk        = pos - w_c;
          slot      = SLW'(1);
          last_word = 1'b1;
        end
      end
      FMT_TDM: begin
        slot      = pos[KW +: SLW];
        kk        = CW'(pos[KW-1:0]);
        en        = (pos < SPAN_C) && (int'(slot) < NUSED) && (kk < w_c);
        last_word = (int'(slot) == NUSED - 1);
      end
      default: begin
        en        = pos < w_c;
        kk        = pos;
        slot      = SLW'(ch);
        last_word = ch;
      end
    endcase
  end

  assign wr_en      = sample && en;
  assign wr_slot    = slot;
  assign wr_pos     = kk[KW-1:0];
  assign frame_done = sample && en && last_word && (armed || arm_now) &&
                      (kk == (w_c - CW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_f <= 1'b0;
      cnt    <= '0;
      ch_r   <= 1'b0;
      armed  <= 1'b0;
    end else if (sample) begin
      prev_f <= fclk;
      cnt    <= (pos == LAST_C) ? pos : pos + CW'(1);
      ch_r   <= ch;
      armed  <= armed | arm_now;
    end
  end

endmodule

// File: rtl/aud_sin_word.sv
module aud_sin_word #(
  parameter int SW = 24,
  parameter int KW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [KW-1:0] pos,
  input  logic          din,
  output logic [SW-1:0] word
);

  logic [SW-1:0] nxt;

  always_comb begin
    nxt = (pos == '0) ? '0 : word;
    if (int'(pos) < SW) nxt[SW-1-int'(pos)] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word <= '0;
    else if (we) word <= nxt;
  end

endmodule

// File: rtl/aud_sin_out.sv
module aud_sin_out #(
  parameter int SW  = 24,
  parameter int NCH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              rep_en,
  input  logic [NCH*SW-1:0] words,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [NCH*SW-1:0] out_data,
  output logic              take
);

  logic              done_q;
  logic [NCH*SW-1:0] routed;

  for (genvar j = 0; j < NCH; j++) begin : g_route
    assign routed[j*SW +: SW] = rep_en ? words[(j % 2)*SW +: SW] : words[j*SW +: SW];
  end

  assign take = done_q && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      done_q <= frame_done;
      if (take) begin
        out_data  <= routed;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/aud_sin_port.sv
module aud_sin_port
  import aud_sin_pkg::*;
#(
  parameter int SW    = 24,
  parameter int NPAIR = 3,
  parameter int HALF  = 32,
  parameter int SLOT  = 32,
  parameter int NSLOT = 8,
  localparam int NCH  = 2 * NPAIR,
  localparam int KW   = $clog2(SLOT),
  localparam int SLW  = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_in,
  input  logic              fclk_in,
  input  logic [NPAIR-1:0]  sd_in,
  input  logic [2:0]        fmt,
  input  logic [1:0]        wlen,
  input  logic              rep_en,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [NCH*SW-1:0] out_data
);

  localparam int NSYNC = NPAIR + 2;

  fmt_e              fmt_v;
  logic [NSYNC-1:0]  sync_v;
  logic              b_rise;
  logic              b_fall;
  logic              sample;
  logic              tdm;
  logic              wr_en;
  logic [SLW-1:0]    wr_slot;
  logic [KW-1:0]     wr_pos;
  logic              frame_done;
  logic              frame_take;
  logic [NCH*SW-1:0] words;
  logic [NPAIR-1:0]  sd_s;

  assign fmt_v  = fmt_e'(fmt);
  assign tdm    = (fmt_v == FMT_TDM);
  assign sample = tdm ? b_fall : b_rise;
  assign sd_s   = sync_v[NSYNC-1:2];

  aud_sin_sync #(.N(NSYNC), .EDGE_BIT(0)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sd_in, fclk_in, bclk_in}),
    .sync_out (sync_v),
    .edge_rise(b_rise),
    .edge_fall(b_fall)
  );

  aud_sin_frame #(.HALF(HALF), .SLOT(SLOT), .NSLOT(NSLOT), .NUSED(NCH)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (sample),
    .fclk      (sync_v[1]),
    .fmt       (fmt_v),
    .wbits     (word_bits(wlen)),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .wr_pos    (wr_pos),
    .frame_done(frame_done)
  );

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    logic sel;
    logic bit_in;
    assign sel    = tdm ? (int'(wr_slot) == j) : (int'(wr_slot) == (j % 2));
    assign bit_in = tdm ? sd_s[0] : sd_s[j / 2];
    aud_sin_word #(.SW(SW), .KW(KW)) u_word (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_en && sel),
      .pos  (wr_pos),
      .din  (bit_in),
      .word (words[j*SW +: SW])
    );
  end

  aud_sin_out #(.SW(SW), .NCH(NCH)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_done(frame_done),
    .rep_en    (rep_en),
    .words     (words),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .take      (frame_take)
  );

endmodule

// File: rtl/aud_sin_chk.sv
module aud_sin_chk #(
  parameter int SW  = 24,
  parameter int NCH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NCH*SW-1:0] out_data,
  input logic              take,
  input logic              rep_en,
  input logic [1:0]        wlen
);

  function automatic logic low_zero(input logic [NCH*SW-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int j = 0; j < NCH; j++) begin
      if (d[j*SW +: (SW-16)] != '0) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic pairs_same(input logic [NCH*SW-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int j = 2; j < NCH; j++) begin
      if (d[j*SW +: SW] != d[(j%2)*SW +: SW]) ok = 1'b0;
    end
    return ok;
  endfunction

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !take |=> !out_valid);

  // R8
  replicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && rep_en |=> pairs_same(out_data));

  // R7
  pad16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && (wlen == 2'd0) |=> low_zero(out_data));

  // R9
  take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

endmodule

bind aud_sin_port aud_sin_chk #(.SW(SW), .NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .take     (frame_take),
  .rep_en   (rep_en),
  .wlen     (wlen)
);

// File: tb/aud_sin_port_bench.sv
module aud_sin_port_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bclk = 1'b0;
  logic         fclk = 1'b0;
  logic [2:0]   sd = '0;
  logic [2:0]   fmt = '0;
  logic [1:0]   wlen = 2'd2;
  logic         rep_en = 1'b0;
  logic         out_ready = 1'b0;
  logic         out_valid;
  logic [143:0] out_data;

  int checks = 0;
  int failures = 0;
  logic [23:0] v [6];

  always #5 clk = ~clk;

  aud_sin_port u_aud_sin_port (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fclk_in(fclk), .sd_in(sd),
    .fmt(fmt), .wlen(wlen), .rep_en(rep_en), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input logic ok, input string req, input logic [143:0] act,
                     input logic [143:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] f, input logic [1:0] wl, input logic rep);
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0; fclk = 1'b0; sd = '0; out_ready = 1'b0;
    fmt = f; wlen = wl; rep_en = rep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bit(input logic f, input logic [2:0] d, input logic fall_mode);
    if (!fall_mode) begin
      fclk = f; sd = d;
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
      bclk = 1'b0;
    end else begin
      bclk = 1'b1; fclk = f; sd = d;
      repeat (4) @(negedge clk);
      bclk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  function automatic logic bitval(input logic [23:0] w, input int k, input int wl);
    if (k >= 0 && k < wl) return w[23-k];
    return 1'b0;
  endfunction

  function automatic logic [143:0] expect_frame(input int wl, input logic rep);
    logic [143:0] e;
    logic [23:0] m;
    m = 24'hFFFFFF << (24 - wl);
    for (int j = 0; j < 6; j++) e[j*24 +: 24] = v[rep ? (j % 2) : j] & m;
    return e;
  endfunction

  task automatic load_vals(input int seed);
    for (int j = 0; j < 6; j++) v[j] = 24'(32'h9E3779B9 * (seed * 8 + j + 1));
  endtask

  // stereo formats: 0 left-aligned, 1 one-bit delayed, 2 right-aligned
  task automatic send_std(input int f, input int wl);
    logic [2:0] d;
    for (int p = 0; p < 4; p++) send_bit((f == 1), 3'b000, 1'b0);
    for (int h = 0; h < 2; h++) begin
      for (int p = 0; p < 32; p++) begin
        for (int j = 0; j < 3; j++) begin
          int k;
          k = (f == 0) ? p : (f == 1) ? p - 1 : p - (32 - wl);
          d[j] = bitval(v[2*j+h], k, wl);
        end
        send_bit((f == 1) ? (h == 1) : (h == 0), d, 1'b0);
      end
    end
  endtask

  task automatic send_dsp(input int wl);
    logic [2:0] d;
    for (int p = 0; p < 4; p++) send_bit(1'b0, 3'b000, 1'b0);
    for (int p = 0; p < 64; p++) begin
      for (int j = 0; j < 3; j++)
        d[j] = (p < wl) ? bitval(v[2*j], p, wl) : bitval(v[2*j+1], p - wl, wl);
      send_bit((p == 0), d, 1'b0);
    end
  endtask

  task automatic send_tdm(input int wl);
    logic [2:0] d;
    for (int p = 0; p < 4; p++) send_bit(1'b0, 3'b110, 1'b1);
    for (int p = 0; p < 256; p++) begin
      int s;
      s = p / 32;
      d[0] = (s < 6) ? bitval(v[s], p % 32, wl) : 1'b1;
      d[2:1] = 2'(p >> 1) ^ 2'b10;
      send_bit((p == 0), d, 1'b1);
    end
  endtask

  task automatic wait_and_check(input string req, input logic [143:0] exp);
    int n;
    n = 0;
    while (!out_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(out_valid && out_data == exp, req, out_data, exp);
  endtask

  task automatic accept_and_check(input string req);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid, req, {143'd0, out_valid}, 144'd0);
  endtask

  task automatic t_reset_state;
    do_reset(3'd0, 2'd2, 1'b0);
    chk(!out_valid && out_data == '0, "R1 reset", {143'd0, out_valid} | out_data, 144'd0);
  endtask

  task automatic t_lj24;
    do_reset(3'd0, 2'd2, 1'b0);
    load_vals(1);
    send_std(0, 24);
    wait_and_check("R2 left-aligned 24b", expect_frame(24, 1'b0));
    accept_and_check("R10 valid drops after accept");
  endtask

  task automatic t_i2s16;
    do_reset(3'd1, 2'd0, 1'b0);
    load_vals(2);
    send_std(1, 16);
    wait_and_check("R3 R7 delayed format 16b", expect_frame(16, 1'b0));
    accept_and_check("R10 valid drops after accept");
  endtask

  task automatic t_rj20;
    do_reset(3'd2, 2'd1, 1'b0);
    load_vals(3);
    send_std(2, 20);
    wait_and_check("R4 R7 right-aligned 20b", expect_frame(20, 1'b0));
    accept_and_check("R10 valid drops after accept");
  endtask

  task automatic t_rj16;
    do_reset(3'd2, 2'd0, 1'b0);
    load_vals(7);
    send_std(2, 16);
    wait_and_check("R4 R7 right-aligned 16b", expect_frame(16, 1'b0));
    accept_and_check("R10 valid drops after accept");
  endtask

  task automatic t_dsp24;
    do_reset(3'd3, 2'd3, 1'b0);
    load_vals(4);
    send_dsp(24);
    wait_and_check("R5 R7 pulse-framed 24b", expect_frame(24, 1'b0));
    accept_and_check("R10 valid drops after accept");
  endtask

  task automatic t_tdm24;
    do_reset(3'd4, 2'd2, 1'b0);
    load_vals(5);
    send_tdm(24);
    wait_and_check("R6 packed 24b", expect_frame(24, 1'b0));
    accept_and_check("R10 valid drops after accept");
  endtask

  task automatic t_tdm16;
    do_reset(3'd4, 2'd0, 1'b0);
    load_vals(6);
    send_tdm(16);
    wait_and_check("R6 R7 packed 16b", expect_frame(16, 1'b0));
    accept_and_check("R10 valid drops after accept");
  endtask

  task automatic t_replicate;
    do_reset(3'd0, 2'd2, 1'b1);
    load_vals(8);
    send_std(0, 24);
    wait_and_check("R8 replicate", expect_frame(24, 1'b1));
    accept_and_check("R10 valid drops after accept");
  endtask

  task automatic t_stall;
    logic [143:0] first;
    do_reset(3'd0, 2'd2, 1'b0);
    load_vals(9);
    first = expect_frame(24, 1'b0);
    send_std(0, 24);
    wait_and_check("R9 first frame", first);
    load_vals(10);
    send_std(0, 24);
    repeat (20) @(negedge clk);
    chk(out_valid && out_data == first, "R9 held during stall", out_data, first);
    accept_and_check("R10 valid drops after stall release");
    repeat (20) @(negedge clk);
    chk(!out_valid, "R9 dropped frame not offered", {143'd0, out_valid}, 144'd0);
  endtask

  initial begin
    t_reset_state();
    t_lj24();
    t_i2s16();
    t_rj20();
    t_rj16();
    t_dsp24();
    t_tdm24();
    t_tdm16();
    t_replicate();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule